// File: doc/BRIEF.md
# Multi-Channel Round-Robin Burst DMA Engine

This block copies blocks of 64-bit words from a source region to a destination region for several independent channels. Software arms a channel by writing its descriptor (source address, destination address, word count and a control word) into a small descriptor memory. That memory has two ports. One port serves a host slave bus. The other port serves the transfer engine, which reads each descriptor when it starts a turn and writes it back when the turn ends.

The engine grants active channels one at a time in round-robin order. Each turn moves exactly one burst. The engine issues pipelined master reads for the whole burst and collects the returned words in a 64-bit staging buffer. Only then does it issue the write burst to the destination. After the last write it stores the advanced addresses, the reduced count and the updated status back into the descriptor memory. It then passes the turn to the next eligible channel.

Top module: `rr_burst_dma`

## Requirements
- R1: After reset, neither master request is asserted and every descriptor word reads back as zero.
- R2: Descriptor word index is channel*4 + field. The fields are: 0 source byte address, 1 destination byte address, 2 remaining length in 64-bit words (low LEN_W bits), 3 control word. The host read data appears on h_rdata_o one clock after h_rd_i is sampled.
- R3: Each burst moves min(remaining length, MAX_BURST) words. That count is shown on m_burst_len_o, and it is between 1 and MAX_BURST whenever a master request is asserted.
- R4: Word i of a burst is read from source + 8*i and written unchanged to destination + 8*i, in order.
- R5: Reads and writes never overlap. The master never asserts both requests at once, and no write is issued while any read of the burst is still unreturned.
- R6: At the end of each burst, the engine writes back the source and destination advanced by 8*burst and the length reduced by the burst. If the new length is nonzero, the control word gets busy (bit 1) set. If the new length is zero, enable (bit 0) and busy are cleared and done (bit 2) is set. The engine leaves all other control bits as they were.
- R7: Eligible channels are served one burst per turn. The search for the next channel starts at the channel after the one last served.
- R8: A channel with enable clear or length zero is never granted, and its descriptor is not modified. With no eligible channel, the engine issues no master requests.
- R9: A master request holds its address (and, for writes, its data) stable while its wait-request input is high.
- R10: A burst uses the descriptor values latched when its turn began. A host write to a word of the channel in flight is not overwritten by that turn's write-back, so the new value takes effect at the channel's next turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_addr_i | input | HA_W | Host descriptor word index |
| h_wr_i | input | 1 | Host write strobe |
| h_wdata_i | input | 64 | Host write data |
| h_rd_i | input | 1 | Host read strobe |
| h_rdata_o | output | 64 | Host read data, one cycle after h_rd_i |
| m_rd_o | output | 1 | Master read request |
| m_rd_addr_o | output | AW | Master read byte address |
| m_rd_wait_i | input | 1 | Read wait-request |
| m_rd_data_i | input | 64 | Read return data |
| m_rd_valid_i | input | 1 | Read return data valid |
| m_wr_o | output | 1 | Master write request |
| m_wr_addr_o | output | AW | Master write byte address |
| m_wr_data_o | output | 64 | Master write data |
| m_wr_wait_i | input | 1 | Write wait-request |
| m_burst_len_o | output | BC_W | Word count of the current burst |

## Verification
The hardest case to reach is a host write that lands on the in-flight channel's descriptor during its write phase, after the latch and before the write-back. The bench arms one channel with two bursts of work, waits at the port for the first write request of the first burst, and then rewrites that channel's destination address. It expects the rest of the first burst to go to the old destination and the second burst to go to the new one. Round-robin order also needs several channels armed before the first turn ends. To get this, the bench writes all descriptors with enable clear and then sets the enables back to back, while the slave model randomly stretches requests and returns to show that the handshake holds.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW = 64;

  localparam logic [1:0] F_SRC = 2'd0;
  localparam logic [1:0] F_DST = 2'd1;
  localparam logic [1:0] F_LEN = 2'd2;
  localparam logic [1:0] F_CTL = 2'd3;

  localparam int C_EN   = 0;
  localparam int C_BUSY = 1;
  localparam int C_DONE = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_READ,
    S_WRITE,
    S_WB
  } seq_state_e;
endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = $clog2(NUM_CH) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  h_addr_i,
  input  logic              h_wr_i,
  input  logic [DW-1:0]     h_wdata_i,
  input  logic              h_rd_i,
  output logic [DW-1:0]     h_rdata_o,
  input  logic [IDX_W-1:0]  e_addr_i,
  input  logic              e_wr_i,
  input  logic [DW-1:0]     e_wdata_i,
  output logic [DW-1:0]     e_rdata_o,
  output logic [NUM_CH-1:0] elig_o
);
  localparam int DEPTH = NUM_CH * 4;

  logic [DW-1:0]     mem_q [DEPTH];
  logic [NUM_CH-1:0] en_q, nz_q;

  // host port is applied last so it wins a same-word collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      en_q      <= '0;
      nz_q      <= '0;
      h_rdata_o <= '0;
    end else begin
      if (e_wr_i) begin
        mem_q[e_addr_i] <= e_wdata_i;
        if (e_addr_i[1:0] == F_CTL) en_q[e_addr_i[IDX_W-1:2]] <= e_wdata_i[C_EN];
        if (e_addr_i[1:0] == F_LEN) nz_q[e_addr_i[IDX_W-1:2]] <= |e_wdata_i[LEN_W-1:0];
      end
      if (h_wr_i) begin
        mem_q[h_addr_i] <= h_wdata_i;
        if (h_addr_i[1:0] == F_CTL) en_q[h_addr_i[IDX_W-1:2]] <= h_wdata_i[C_EN];
        if (h_addr_i[1:0] == F_LEN) nz_q[h_addr_i[IDX_W-1:2]] <= |h_wdata_i[LEN_W-1:0];
      end
      if (h_rd_i) h_rdata_o <= mem_q[h_addr_i];
    end
  end

  assign e_rdata_o = mem_q[e_addr_i];
  assign elig_o    = en_q & nz_q;
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [CH_W-1:0]   ptr_i,
  output logic [CH_W-1:0]   gnt_o,
  output logic              any_o
);
  logic [CH_W-1:0] idx;

  // scan from farthest to nearest so the nearest requester is the last to win
  always_comb begin
    gnt_o = '0;
    any_o = 1'b0;
    idx   = '0;
    for (int off = NUM_CH - 1; off >= 0; off--) begin
      idx = ptr_i + CH_W'(off);
      if (req_i[idx]) begin
        gnt_o = idx;
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf
  import dma_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] buf_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) buf_q[wr_idx_i] <= wdata_i;
  end

  assign rdata_o = buf_q[rd_idx_i];
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int AW        = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  parameter int CH_W      = $clog2(NUM_CH),
  parameter int IDX_W     = CH_W + 2,
  parameter int BC_W      = $clog2(MAX_BURST + 1),
  parameter int BI_W      = $clog2(MAX_BURST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  gnt_i,
  input  logic             gnt_any_i,
  output logic [CH_W-1:0]  ptr_o,
  input  logic             h_wr_i,
  input  logic [IDX_W-1:0] h_addr_i,
  output logic [IDX_W-1:0] e_addr_o,
  output logic             e_wr_o,
  output logic [DW-1:0]    e_wdata_o,
  input  logic [DW-1:0]    e_rdata_i,
  output logic             buf_wr_o,
  output logic [BI_W-1:0]  buf_wr_idx_o,
  output logic [DW-1:0]    buf_wdata_o,
  output logic [BI_W-1:0]  buf_rd_idx_o,
  input  logic [DW-1:0]    buf_rdata_i,
  output logic             m_rd_o,
  output logic [AW-1:0]    m_rd_addr_o,
  input  logic             m_rd_wait_i,
  input  logic [DW-1:0]    m_rd_data_i,
  input  logic             m_rd_valid_i,
  output logic             m_wr_o,
  output logic [AW-1:0]    m_wr_addr_o,
  output logic [DW-1:0]    m_wr_data_o,
  input  logic             m_wr_wait_i,
  output logic [BC_W-1:0]  burst_len_o
);
  seq_state_e       st_q;
  logic [CH_W-1:0]  ch_q, ptr_q, nxt_ch;
  logic [1:0]       fld_q;
  logic [AW-1:0]    src_q, dst_q, step;
  logic [LEN_W-1:0] len_q, new_len;
  logic [DW-1:0]    ctl_q, ctl_wb;
  logic [BC_W-1:0]  blen_q, rd_iss_q, rd_got_q, wr_cnt_q, len_clip;
  logic [3:0]       dirty_q;
  logic             rd_fire, wr_fire, last_rd;

  assign nxt_ch   = (ch_q == CH_W'(NUM_CH - 1)) ? '0 : ch_q + 1'b1;
  assign len_clip = (len_q > LEN_W'(MAX_BURST)) ? BC_W'(MAX_BURST) : BC_W'(len_q);
  assign step     = AW'(blen_q) << 3;
  assign new_len  = len_q - LEN_W'(blen_q);

  assign m_rd_o      = (st_q == S_READ) && (rd_iss_q < blen_q);
  assign m_rd_addr_o = src_q + (AW'(rd_iss_q) << 3);
  assign rd_fire     = m_rd_o && !m_rd_wait_i;
  assign last_rd     = m_rd_valid_i && (rd_got_q == blen_q - 1'b1);

  assign m_wr_o      = (st_q == S_WRITE);
  assign m_wr_addr_o = dst_q + (AW'(wr_cnt_q) << 3);
  assign m_wr_data_o = buf_rdata_i;
  assign wr_fire     = m_wr_o && !m_wr_wait_i;

  assign buf_wr_o     = (st_q == S_READ) && m_rd_valid_i;
  assign buf_wr_idx_o = rd_got_q[BI_W-1:0];
  assign buf_wdata_o  = m_rd_data_i;
  assign buf_rd_idx_o = wr_cnt_q[BI_W-1:0];

  assign burst_len_o = blen_q;
  assign ptr_o       = ptr_q;

  always_comb begin
    ctl_wb = ctl_q;
    if (new_len == '0) begin
      ctl_wb[C_EN]   = 1'b0;
      ctl_wb[C_BUSY] = 1'b0;
      ctl_wb[C_DONE] = 1'b1;
    end else begin
      ctl_wb[C_BUSY] = 1'b1;
    end
  end

  assign e_addr_o = {ch_q, fld_q};
  assign e_wr_o   = (st_q == S_WB) && !dirty_q[fld_q];

  always_comb begin
    case (fld_q)
      F_SRC:   e_wdata_o = DW'(src_q + step);
      F_DST:   e_wdata_o = DW'(dst_q + step);
      F_LEN:   e_wdata_o = DW'(new_len);
      default: e_wdata_o = ctl_wb;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ch_q     <= '0;
      ptr_q    <= '0;
      fld_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      ctl_q    <= '0;
      blen_q   <= '0;
      rd_iss_q <= '0;
      rd_got_q <= '0;
      wr_cnt_q <= '0;
      dirty_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          rd_iss_q <= '0;
          rd_got_q <= '0;
          wr_cnt_q <= '0;
          fld_q    <= '0;
          if (gnt_any_i) begin
            ch_q    <= gnt_i;
            dirty_q <= '0;
            st_q    <= S_LOAD;
          end
        end
        S_LOAD: begin
          fld_q <= fld_q + 1'b1;
          case (fld_q)
            F_SRC: src_q <= e_rdata_i[AW-1:0];
            F_DST: dst_q <= e_rdata_i[AW-1:0];
            F_LEN: len_q <= e_rdata_i[LEN_W-1:0];
            default: begin
              ctl_q <= e_rdata_i;
              // re-check: the host may have disarmed between grant and latch
              if (e_rdata_i[C_EN] && len_q != '0) begin
                blen_q <= len_clip;
                st_q   <= S_READ;
              end else begin
                ptr_q <= nxt_ch;
                st_q  <= S_IDLE;
              end
            end
          endcase
        end
        S_READ: begin
          if (rd_fire) rd_iss_q <= rd_iss_q + 1'b1;
          if (m_rd_valid_i) begin
            rd_got_q <= rd_got_q + 1'b1;
            if (last_rd) st_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_fire) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
            if (wr_cnt_q == blen_q - 1'b1) st_q <= S_WB;
          end
        end
        S_WB: begin
          fld_q <= fld_q + 1'b1;
          if (fld_q == F_CTL) begin
            ptr_q <= nxt_ch;
            st_q  <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      // a host-written word of the in-flight channel keeps the host value
      if (st_q != S_IDLE && h_wr_i && h_addr_i[IDX_W-1:2] == ch_q)
        dirty_q[h_addr_i[1:0]] <= 1'b1;
    end
  end
endmodule

// File: rtl/rr_burst_dma.sv
module rr_burst_dma
  import dma_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int AW        = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int HA_W     = CH_W + 2,
  localparam int BC_W     = $clog2(MAX_BURST + 1),
  localparam int BI_W     = $clog2(MAX_BURST)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HA_W-1:0] h_addr_i,
  input  logic            h_wr_i,
  input  logic [DW-1:0]   h_wdata_i,
  input  logic            h_rd_i,
  output logic [DW-1:0]   h_rdata_o,
  output logic            m_rd_o,
  output logic [AW-1:0]   m_rd_addr_o,
  input  logic            m_rd_wait_i,
  input  logic [DW-1:0]   m_rd_data_i,
  input  logic            m_rd_valid_i,
  output logic            m_wr_o,
  output logic [AW-1:0]   m_wr_addr_o,
  output logic [DW-1:0]   m_wr_data_o,
  input  logic            m_wr_wait_i,
  output logic [BC_W-1:0] m_burst_len_o
);
  logic [NUM_CH-1:0] elig;
  logic [CH_W-1:0]   gnt, ptr;
  logic              gnt_any;
  logic [HA_W-1:0]   e_addr;
  logic              e_wr;
  logic [DW-1:0]     e_wdata, e_rdata;
  logic              buf_wr;
  logic [BI_W-1:0]   buf_wr_idx, buf_rd_idx;
  logic [DW-1:0]     buf_wdata, buf_rdata;

  dma_desc_ram #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .IDX_W(HA_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_addr_i  (h_addr_i),
    .h_wr_i    (h_wr_i),
    .h_wdata_i (h_wdata_i),
    .h_rd_i    (h_rd_i),
    .h_rdata_o (h_rdata_o),
    .e_addr_i  (e_addr),
    .e_wr_i    (e_wr),
    .e_wdata_i (e_wdata),
    .e_rdata_o (e_rdata),
    .elig_o    (elig)
  );

  dma_rr_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .req_i (elig),
    .ptr_i (ptr),
    .gnt_o (gnt),
    .any_o (gnt_any)
  );

  dma_stage_buf #(.DEPTH(MAX_BURST), .IDX_W(BI_W)) u_buf (
    .clk_i    (clk_i),
    .wr_i     (buf_wr),
    .wr_idx_i (buf_wr_idx),
    .wdata_i  (buf_wdata),
    .rd_idx_i (buf_rd_idx),
    .rdata_o  (buf_rdata)
  );

  dma_burst_seq #(
    .NUM_CH(NUM_CH), .AW(AW), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST),
    .CH_W(CH_W), .IDX_W(HA_W), .BC_W(BC_W), .BI_W(BI_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gnt_i        (gnt),
    .gnt_any_i    (gnt_any),
    .ptr_o        (ptr),
    .h_wr_i       (h_wr_i),
    .h_addr_i     (h_addr_i),
    .e_addr_o     (e_addr),
    .e_wr_o       (e_wr),
    .e_wdata_o    (e_wdata),
    .e_rdata_i    (e_rdata),
    .buf_wr_o     (buf_wr),
    .buf_wr_idx_o (buf_wr_idx),
    .buf_wdata_o  (buf_wdata),
    .buf_rd_idx_o (buf_rd_idx),
    .buf_rdata_i  (buf_rdata),
    .m_rd_o       (m_rd_o),
    .m_rd_addr_o  (m_rd_addr_o),
    .m_rd_wait_i  (m_rd_wait_i),
    .m_rd_data_i  (m_rd_data_i),
    .m_rd_valid_i (m_rd_valid_i),
    .m_wr_o       (m_wr_o),
    .m_wr_addr_o  (m_wr_addr_o),
    .m_wr_data_o  (m_wr_data_o),
    .m_wr_wait_i  (m_wr_wait_i),
    .burst_len_o  (m_burst_len_o)
  );
endmodule

// File: rtl/rr_burst_dma_chk.sv
module rr_burst_dma_chk #(
  parameter int AW        = 32,
  parameter int MAX_BURST = 8,
  parameter int BC_W      = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            m_rd_o,
  input logic [AW-1:0]   m_rd_addr_o,
  input logic            m_rd_wait_i,
  input logic            m_wr_o,
  input logic [AW-1:0]   m_wr_addr_o,
  input logic [63:0]     m_wr_data_o,
  input logic            m_wr_wait_i,
  input logic [BC_W-1:0] m_burst_len_o
);
  a_r5_no_dual_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_rd_o && m_wr_o));

  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rd_o && m_rd_wait_i) |=> (m_rd_o && $stable(m_rd_addr_o)));

  a_r9_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr_o && m_wr_wait_i) |=> (m_wr_o && $stable(m_wr_addr_o) && $stable(m_wr_data_o)));

  a_r3_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rd_o || m_wr_o) |-> (m_burst_len_o != '0 && m_burst_len_o <= BC_W'(MAX_BURST)));

  a_r4_wr_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr_o && !m_wr_wait_i) |=> (!m_wr_o || m_wr_addr_o == $past(m_wr_addr_o) + AW'(8)));
endmodule

bind rr_burst_dma rr_burst_dma_chk #(.AW(AW), .MAX_BURST(MAX_BURST), .BC_W(BC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .m_rd_o        (m_rd_o),
  .m_rd_addr_o   (m_rd_addr_o),
  .m_rd_wait_i   (m_rd_wait_i),
  .m_wr_o        (m_wr_o),
  .m_wr_addr_o   (m_wr_addr_o),
  .m_wr_data_o   (m_wr_data_o),
  .m_wr_wait_i   (m_wr_wait_i),
  .m_burst_len_o (m_burst_len_o)
);

// File: tb/rr_burst_dma_bench.sv
module rr_burst_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA_W = 4;
  localparam int BC_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [HA_W-1:0] h_addr = '0;
  logic            h_wr = 1'b0, h_rd = 1'b0;
  logic [63:0]     h_wdata = '0, h_rdata;
  logic            m_rd, m_wr, rd_wait = 1'b0, wr_wait = 1'b0, rd_valid = 1'b0;
  logic [31:0]     m_rd_addr, m_wr_addr;
  logic [63:0]     rd_data = '0, m_wr_data;
  logic [BC_W-1:0] blen;

  rr_burst_dma u_rr_burst_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .h_addr_i(h_addr), .h_wr_i(h_wr), .h_wdata_i(h_wdata), .h_rd_i(h_rd), .h_rdata_o(h_rdata),
    .m_rd_o(m_rd), .m_rd_addr_o(m_rd_addr), .m_rd_wait_i(rd_wait),
    .m_rd_data_i(rd_data), .m_rd_valid_i(rd_valid),
    .m_wr_o(m_wr), .m_wr_addr_o(m_wr_addr), .m_wr_data_o(m_wr_data), .m_wr_wait_i(wr_wait),
    .m_burst_len_o(blen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // slave model state
  logic [31:0] pend [0:63];
  int ph = 0, pt = 0, pcnt = 0, viol = 0, rd_acc = 0, nb = 0, wbeat = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit stress = 0;
  logic [63:0] wmem [0:1023];
  int blog_len [0:63];
  logic [31:0] blog_dst [0:63];

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_0000};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_wait = stress && lfsr[0];
      wr_wait = stress && lfsr[1];
      if (m_rd && m_wr) viol++;
      if (m_wr && pcnt != 0) viol++;
      rd_valid = 1'b0;
      if (pcnt > 0 && (!stress || lfsr[2])) begin
        rd_valid = 1'b1;
        rd_data  = pat(pend[ph]);
        ph = (ph + 1) % 64;
        pcnt--;
      end
      if (m_rd && !rd_wait) begin
        pend[pt] = m_rd_addr;
        pt = (pt + 1) % 64;
        pcnt++;
        rd_acc++;
      end
      if (m_wr && !wr_wait) begin
        wmem[m_wr_addr[12:3]] = m_wr_data;
        if (wbeat == 0) begin
          blog_len[nb] = int'(blen);
          blog_dst[nb] = m_wr_addr;
          nb++;
        end
        wbeat++;
        if (wbeat == int'(blen)) wbeat = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int ch, input int fld, input logic [63:0] d);
    @(negedge clk);
    h_addr = HA_W'(ch * 4 + fld);
    h_wdata = d;
    h_wr = 1'b1;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic host_rd(input int ch, input int fld, output logic [63:0] d);
    @(negedge clk);
    h_addr = HA_W'(ch * 4 + fld);
    h_rd = 1'b1;
    @(negedge clk);
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic program_ch(input int ch, input logic [31:0] src, input logic [31:0] dst,
                            input int len, input logic [63:0] ctl);
    host_wr(ch, 0, 64'(src));
    host_wr(ch, 1, 64'(dst));
    host_wr(ch, 2, 64'(len));
    host_wr(ch, 3, ctl);
  endtask

  task automatic wait_done(input int ch, input string tag);
    logic [63:0] d;
    bit seen = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      host_rd(ch, 3, d);
      if (d[2]) seen = 1;
    end
    chk(tag, 64'(seen), 64'd1);
  endtask

  task automatic check_copy(input string tag, input logic [31:0] src, input logic [31:0] dst, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] da = dst + 32'(8 * i);
      chk(tag, wmem[da[12:3]], pat(src + 32'(8 * i)));
    end
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 rd req after reset", 64'(m_rd), 64'd0);
    chk("R1 wr req after reset", 64'(m_wr), 64'd0);
    host_rd(0, 0, d); chk("R1 desc word 0", d, 64'd0);
    host_rd(3, 3, d); chk("R1 desc word 15", d, 64'd0);
  endtask

  task automatic t_single();
    logic [63:0] d;
    int b0 = nb;
    program_ch(1, 32'h0001_0000, 32'h0000_0100, 5, 64'h101);
    wait_done(1, "R6 single done");
    chk("R3 single burst count", 64'(nb - b0), 64'd1);
    chk("R3 single burst len", 64'(blog_len[b0]), 64'd5);
    check_copy("R4 single data", 32'h0001_0000, 32'h0000_0100, 5);
    host_rd(1, 0, d); chk("R6 src advanced", d, 64'h0001_0028);
    host_rd(1, 1, d); chk("R2 R6 dst advanced", d, 64'h0000_0128);
    host_rd(1, 2, d); chk("R6 len zero", d, 64'd0);
    host_rd(1, 3, d); chk("R6 ctl done, other bits kept", d, 64'h104);
  endtask

  task automatic t_split();
    logic [63:0] d;
    bit seen = 0;
    int b0 = nb;
    stress = 1;
    program_ch(2, 32'h0002_0000, 32'h0000_0200, 20, 64'h1);
    for (int k = 0; k < 3000 && !seen; k++) begin
      host_rd(2, 2, d);
      if (d == 64'd12) seen = 1;
    end
    chk("R6 len after first burst", 64'(seen), 64'd1);
    host_rd(2, 3, d); chk("R6 busy while remaining", d, 64'h3);
    wait_done(2, "R9 split done under stalls");
    stress = 0;
    chk("R3 split burst count", 64'(nb - b0), 64'd3);
    chk("R3 burst 0 len", 64'(blog_len[b0]), 64'd8);
    chk("R3 burst 1 len", 64'(blog_len[b0 + 1]), 64'd8);
    chk("R3 burst 2 len", 64'(blog_len[b0 + 2]), 64'd4);
    chk("R4 burst 2 dst", 64'(blog_dst[b0 + 2]), 64'h280);
    check_copy("R9 R4 split data", 32'h0002_0000, 32'h0000_0200, 20);
    chk("R5 no overlap so far", 64'(viol), 64'd0);
  endtask

  task automatic t_rr();
    logic [63:0] d;
    int b0 = nb;
    logic [31:0] exp_dst [0:5];
    program_ch(3, 32'h0007_0000, 32'h0000_0700, 4, 64'h0);
    program_ch(0, 32'h0004_0000, 32'h0000_0400, 16, 64'h0);
    program_ch(1, 32'h0005_0000, 32'h0000_0500, 16, 64'h0);
    program_ch(2, 32'h0006_0000, 32'h0000_0600, 16, 64'h0);
    host_wr(0, 3, 64'h1);
    host_wr(1, 3, 64'h1);
    host_wr(2, 3, 64'h1);
    wait_done(0, "R7 ch0 done");
    wait_done(1, "R7 ch1 done");
    wait_done(2, "R7 ch2 done");
    exp_dst = '{32'h400, 32'h500, 32'h600, 32'h440, 32'h540, 32'h640};
    chk("R7 rr burst count", 64'(nb - b0), 64'd6);
    for (int i = 0; i < 6; i++) chk("R7 rr order", 64'(blog_dst[b0 + i]), 64'(exp_dst[i]));
    check_copy("R4 ch1 data", 32'h0005_0000, 32'h0000_0500, 16);
    host_rd(3, 2, d); chk("R8 disabled ch len kept", d, 64'd4);
    host_rd(3, 3, d); chk("R8 disabled ch ctl kept", d, 64'd0);
    begin
      int acc0;
      host_wr(3, 2, 64'd0);
      host_wr(3, 3, 64'h1);
      acc0 = rd_acc;
      repeat (40) @(negedge clk);
      chk("R8 zero-len ch no reads", 64'(rd_acc), 64'(acc0));
      host_rd(3, 3, d); chk("R8 zero-len ctl kept", d, 64'h1);
    end
  endtask

  task automatic t_latch();
    logic [63:0] d;
    int b0 = nb;
    program_ch(0, 32'h0003_0000, 32'h0000_0800, 16, 64'h1);
    while (!m_wr) @(negedge clk);
    host_wr(0, 1, 64'h0000_0A00);
    wait_done(0, "R10 latch done");
    chk("R10 burst count", 64'(nb - b0), 64'd2);
    chk("R10 first burst old dst", 64'(blog_dst[b0]), 64'h800);
    chk("R10 second burst new dst", 64'(blog_dst[b0 + 1]), 64'hA00);
    check_copy("R10 first burst data", 32'h0003_0000, 32'h0000_0800, 8);
    check_copy("R10 second burst data", 32'h0003_0040, 32'h0000_0A00, 8);
    host_rd(0, 1, d); chk("R10 dst after new base", d, 64'h0000_0A40);
    host_rd(0, 0, d); chk("R10 src advanced twice", d, 64'h0003_0080);
    chk("R5 no overlap overall", 64'(viol), 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++;
    miscompares++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) wmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_rr();
    t_latch();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule